// File: doc/BRIEF.md
# Windowed Activity Monitor with Watermarks

This block measures how busy a client is. While the monitor is switched on, every cycle with the activity input high adds a programmable weight to a running total. A period tick comes from a prescaler that several monitors share. When the tick arrives and periodic sampling is allowed, the block latches the total as the sample of the finished period and restarts the total. It then advances an exponentially weighted moving average toward that sample. The averaging window is a power of two chosen by software.

The block compares each new sample with an upper and a lower watermark. A raw watermark event is reported only when its condition holds for a programmed number of consecutive periods. The average is checked against its own upper and lower thresholds with no debounce. Events latch into a write-one-to-clear status word. A level interrupt is raised when any latched event has its enable set and the monitor is on. Software uses the interrupt to retune a clock. Software talks to the block through a single-cycle register port: writes take effect at the clock edge and reads are combinational.

Top module: `amonTop`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: With the monitor on (control bit 31), each cycle with `actPulse` high adds the count-weight register (offset 0x18) to a running total. On a sampling tick, the total of the finished period is copied to the count register (0x1C) and the running total restarts. A pulse in the tick cycle counts toward the new period. While the monitor is off, the running total is held at zero.
- R3: The running total saturates at all ones and never wraps.
- R4: On each sampling tick the average register (0x20) becomes avg + ((sample − avg) >>> (K+1)), where K is control bits 12:10. The difference is signed and the shift rounds toward minus infinity.
- R5: A write to offset 0x0C loads the average with the written value. In the same cycle as a sampling tick, the load wins.
- R6: Status bit 31 sets when sample > upper watermark (0x04) has held for N+1 consecutive samples, where N is control bits 28:26. Any sample that fails the test restarts the run.
- R7: Status bit 30 sets when sample < lower watermark (0x08) has held for M+1 consecutive samples, where M is control bits 25:23.
- R8: Status bit 24 sets on a sample whose new average is above the average upper threshold (0x10). Status bit 25 sets on a sample whose new average is below the average lower threshold (0x14).
- R9: A write to status (0x24) clears the bits written as one and leaves the bits written as zero. An event that sets a bit in the same cycle as its clear wins.
- R10: `irq` is high exactly when the monitor is on and a status bit is set with its enable: bit 31 with control bit 30, bit 30 with bit 29, bit 24 with bit 21, and bit 25 with bit 20.
- R11: A tick samples only when control bits 31 and 18 are both set. Otherwise the count and the average hold.
- R12: One cycle after the monitor is off, status reads zero and the debounce runs are reset.
- R13: The control, watermark, threshold and weight registers read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| actPulse | input | 1 | Activity pulse, one weight per high cycle |
| periodTick | input | 1 | End-of-period tick from the shared prescaler |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of operations can land on the same clock edge. A sampling tick can set a status bit while a software write clears that same bit. A sampling tick can also advance the average while a software write loads the average's initial value. The bench provokes each collision by raising `periodTick` and `regWrEn` in one cycle. It expects the freshly detected event to stay latched in status, and the loaded value to replace the computed update. Both results are judged by reading the registers back on the next cycle. The scoreboard also follows a signed average step that rounds down, and a watermark run that is broken in the middle.

// File: rtl/amon_pkg.sv
package amon_pkg;
  localparam int unsigned AMON_AW = 8;

  localparam logic [AMON_AW-1:0] OFF_CTRL    = 8'h00;
  localparam logic [AMON_AW-1:0] OFF_UPWM    = 8'h04;
  localparam logic [AMON_AW-1:0] OFF_DNWM    = 8'h08;
  localparam logic [AMON_AW-1:0] OFF_AVGINIT = 8'h0C;
  localparam logic [AMON_AW-1:0] OFF_AVGUP   = 8'h10;
  localparam logic [AMON_AW-1:0] OFF_AVGDN   = 8'h14;
  localparam logic [AMON_AW-1:0] OFF_WEIGHT  = 8'h18;
  localparam logic [AMON_AW-1:0] OFF_COUNT   = 8'h1C;
  localparam logic [AMON_AW-1:0] OFF_AVG     = 8'h20;
  localparam logic [AMON_AW-1:0] OFF_STAT    = 8'h24;

  // control word fields
  localparam int unsigned B_EN       = 31;
  localparam int unsigned B_UPEN     = 30;
  localparam int unsigned B_DNEN     = 29;
  localparam int unsigned F_UPN_LO   = 26;
  localparam int unsigned F_DNN_LO   = 23;
  localparam int unsigned B_AVGUPEN  = 21;
  localparam int unsigned B_AVGDNEN  = 20;
  localparam int unsigned B_PERIODIC = 18;
  localparam int unsigned F_K_LO     = 10;

  // status word fields
  localparam int unsigned S_UP    = 31;
  localparam int unsigned S_DN    = 30;
  localparam int unsigned S_AVGDN = 25;
  localparam int unsigned S_AVGUP = 24;
  localparam logic [31:0] STAT_MASK = 32'hC300_0000;

  // control -> datapath strobes
  typedef struct packed {
    logic sample;
    logic flush;
    logic loadAvg;
  } dpCmd_t;

  // datapath -> control comparison results, valid in a sample cycle
  typedef struct packed {
    logic cntAbove;
    logic cntBelow;
    logic avgAbove;
    logic avgBelow;
  } dpFlags_t;
endpackage

// File: rtl/amonDebounce.sv
module amonDebounce #(
  parameter int unsigned RUN_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clear,
  input  logic             step,
  input  logic             hit,
  input  logic [RUN_W-1:0] limit,
  output logic             fire
);
  logic [RUN_W-1:0] runQ;

  assign fire = step & hit & (runQ == limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ <= '0;
    end else if (clear) begin
      runQ <= '0;
    end else if (step) begin
      if (!hit)                runQ <= '0;
      else if (runQ != limit)  runQ <= runQ + 1'b1;
    end
  end
endmodule

// File: rtl/amonDatapath.sv
module amonDatapath
  import amon_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned K_W    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic              actPulse,
  input  logic [K_W-1:0]    kShift,
  input  logic [DATA_W-1:0] weight,
  input  logic [DATA_W-1:0] upWm,
  input  logic [DATA_W-1:0] dnWm,
  input  logic [DATA_W-1:0] avgUp,
  input  logic [DATA_W-1:0] avgDn,
  input  logic [DATA_W-1:0] avgInit,
  output logic [DATA_W-1:0] countQ,
  output logic [DATA_W-1:0] avgQ,
  output dpFlags_t          flags
);
  localparam int unsigned SUM_W = DATA_W + 1;

  logic [DATA_W-1:0] accQ;
  logic [DATA_W-1:0] addend;
  logic [SUM_W-1:0]  sumWide;
  logic [DATA_W-1:0] accSat;
  logic signed [SUM_W-1:0] diff;
  logic [K_W:0]      shAmt;
  logic [DATA_W-1:0] avgNext;

  assign addend  = actPulse ? weight : '0;
  assign sumWide = {1'b0, accQ} + {1'b0, addend};
  assign accSat  = sumWide[DATA_W] ? '1 : sumWide[DATA_W-1:0];

  assign diff    = $signed({1'b0, accQ}) - $signed({1'b0, avgQ});
  assign shAmt   = {1'b0, kShift} + 1'b1;
  assign avgNext = avgQ + DATA_W'(diff >>> shAmt);

  always_comb begin
    flags.cntAbove = accQ > upWm;
    flags.cntBelow = accQ < dnWm;
    flags.avgAbove = avgNext > avgUp;
    flags.avgBelow = avgNext < avgDn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ <= '0;
    end else if (cmd.flush) begin
      accQ <= '0;
    end else if (cmd.sample) begin
      accQ <= addend;
    end else begin
      accQ <= accSat;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (cmd.sample) begin
      countQ <= accQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      avgQ <= '0;
    end else if (cmd.loadAvg) begin
      avgQ <= avgInit;
    end else if (cmd.sample) begin
      avgQ <= avgNext;
    end
  end
endmodule

// File: rtl/amonCtrl.sv
module amonCtrl
  import amon_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned RUN_W  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [AMON_AW-1:0] regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic               periodTick,
  input  dpFlags_t           flags,
  output dpCmd_t             cmd,
  output logic [DATA_W-1:0]  ctrlQ,
  output logic [DATA_W-1:0]  upWmQ,
  output logic [DATA_W-1:0]  dnWmQ,
  output logic [DATA_W-1:0]  avgUpQ,
  output logic [DATA_W-1:0]  avgDnQ,
  output logic [DATA_W-1:0]  weightQ,
  output logic [DATA_W-1:0]  statusQ,
  output logic               irq
);
  localparam int unsigned NUM_DB = 2;
  localparam logic [DATA_W-1:0] STAT_M = DATA_W'(STAT_MASK);

  logic devEn;
  logic [NUM_DB-1:0] dbHit;
  logic [NUM_DB-1:0] dbFire;
  logic [NUM_DB-1:0][RUN_W-1:0] dbLimit;
  logic [DATA_W-1:0] setVec;
  logic [DATA_W-1:0] clrVec;
  logic [DATA_W-1:0] enVec;

  assign devEn       = ctrlQ[B_EN];
  assign cmd.sample  = devEn & ctrlQ[B_PERIODIC] & periodTick;
  assign cmd.flush   = ~devEn;
  assign cmd.loadAvg = regWrEn & (regAddr == OFF_AVGINIT);

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      upWmQ   <= '0;
      dnWmQ   <= '0;
      avgUpQ  <= '0;
      avgDnQ  <= '0;
      weightQ <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        OFF_CTRL:   ctrlQ   <= regWrData;
        OFF_UPWM:   upWmQ   <= regWrData;
        OFF_DNWM:   dnWmQ   <= regWrData;
        OFF_AVGUP:  avgUpQ  <= regWrData;
        OFF_AVGDN:  avgDnQ  <= regWrData;
        OFF_WEIGHT: weightQ <= regWrData;
        default: ;
      endcase
    end
  end

  // index 1: upper raw watermark, index 0: lower raw watermark
  assign dbHit      = {flags.cntAbove, flags.cntBelow};
  assign dbLimit[1] = ctrlQ[F_UPN_LO +: RUN_W];
  assign dbLimit[0] = ctrlQ[F_DNN_LO +: RUN_W];

  for (genvar g = 0; g < NUM_DB; g++) begin : gDb
    amonDebounce #(.RUN_W(RUN_W)) uDb (
      .clk   (clk),
      .rstN  (rstN),
      .clear (~devEn),
      .step  (cmd.sample),
      .hit   (dbHit[g]),
      .limit (dbLimit[g]),
      .fire  (dbFire[g])
    );
  end

  always_comb begin
    setVec          = '0;
    setVec[S_UP]    = dbFire[1];
    setVec[S_DN]    = dbFire[0];
    setVec[S_AVGUP] = cmd.sample & flags.avgAbove;
    setVec[S_AVGDN] = cmd.sample & flags.avgBelow;
    enVec           = '0;
    enVec[S_UP]     = ctrlQ[B_UPEN];
    enVec[S_DN]     = ctrlQ[B_DNEN];
    enVec[S_AVGUP]  = ctrlQ[B_AVGUPEN];
    enVec[S_AVGDN]  = ctrlQ[B_AVGDNEN];
  end

  assign clrVec = (regWrEn && regAddr == OFF_STAT) ? (regWrData & STAT_M) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
    end else if (!devEn) begin
      statusQ <= '0;
    end else begin
      statusQ <= (statusQ & ~clrVec) | setVec;
    end
  end

  assign irq = devEn & (|(statusQ & enVec));
endmodule

// File: rtl/amonTop.sv
module amonTop
  import amon_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned RUN_W  = 3,
  parameter int unsigned K_W    = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [AMON_AW-1:0] regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic               actPulse,
  input  logic               periodTick,
  output logic               irq
);
  dpCmd_t   cmd;
  dpFlags_t flags;
  logic [DATA_W-1:0] ctrlQ, upWmQ, dnWmQ, avgUpQ, avgDnQ, weightQ, statusQ;
  logic [DATA_W-1:0] countQ, avgQ;

  amonCtrl #(.DATA_W(DATA_W), .RUN_W(RUN_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .periodTick (periodTick),
    .flags      (flags),
    .cmd        (cmd),
    .ctrlQ      (ctrlQ),
    .upWmQ      (upWmQ),
    .dnWmQ      (dnWmQ),
    .avgUpQ     (avgUpQ),
    .avgDnQ     (avgDnQ),
    .weightQ    (weightQ),
    .statusQ    (statusQ),
    .irq        (irq)
  );

  amonDatapath #(.DATA_W(DATA_W), .K_W(K_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .actPulse (actPulse),
    .kShift   (ctrlQ[F_K_LO +: K_W]),
    .weight   (weightQ),
    .upWm     (upWmQ),
    .dnWm     (dnWmQ),
    .avgUp    (avgUpQ),
    .avgDn    (avgDnQ),
    .avgInit  (regWrData),
    .countQ   (countQ),
    .avgQ     (avgQ),
    .flags    (flags)
  );

  always_comb begin
    case (regAddr)
      OFF_CTRL:   regRdData = ctrlQ;
      OFF_UPWM:   regRdData = upWmQ;
      OFF_DNWM:   regRdData = dnWmQ;
      OFF_AVGUP:  regRdData = avgUpQ;
      OFF_AVGDN:  regRdData = avgDnQ;
      OFF_WEIGHT: regRdData = weightQ;
      OFF_COUNT:  regRdData = countQ;
      OFF_AVG:    regRdData = avgQ;
      OFF_STAT:   regRdData = statusQ;
      default:    regRdData = '0;
    endcase
  end
endmodule

// File: rtl/amonTop_chk.sv
module amonTop_chk
  import amon_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic [AMON_AW-1:0] regAddr,
  input logic [DATA_W-1:0]  regWrData,
  input logic               periodTick,
  input logic               irq,
  input logic [DATA_W-1:0]  ctrlQ,
  input logic [DATA_W-1:0]  statusQ,
  input logic [DATA_W-1:0]  countQ,
  input logic [DATA_W-1:0]  avgQ
);
  logic sampleEdge;
  assign sampleEdge = ctrlQ[B_EN] & ctrlQ[B_PERIODIC] & periodTick;

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ[B_EN] |-> !irq); // R10

  AST_STATUS_CLEARED_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlQ[B_EN] |=> (statusQ == '0)); // R12

  AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !sampleEdge |=> $stable(countQ)); // R11

  AST_STATUS_SETS_ON_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    !sampleEdge |=> ((statusQ & ~$past(statusQ)) == '0)); // R9

  AST_AVG_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == OFF_AVGINIT) |=> (avgQ == $past(regWrData))); // R5
endmodule

bind amonTop amonTop_chk #(.DATA_W(DATA_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .regWrEn    (regWrEn),
  .regAddr    (regAddr),
  .regWrData  (regWrData),
  .periodTick (periodTick),
  .irq        (irq),
  .ctrlQ      (ctrlQ),
  .statusQ    (statusQ),
  .countQ     (countQ),
  .avgQ       (avgQ)
);

// File: tb/amonTop_test.sv
`timescale 1ns/1ps
module amonTop_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        actPulse = 1'b0;
  logic        periodTick = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  localparam logic [31:0] EN = 32'h8000_0000, UPEN = 32'h4000_0000,
                          DNEN = 32'h2000_0000, AUPEN = 32'h0020_0000,
                          ADNEN = 32'h0010_0000, PER = 32'h0004_0000;
  localparam logic [7:0] IRQ_SEL = 8'hFF;

  typedef struct {
    string       req;
    logic [7:0]  addr;
    logic [31:0] exp;
  } item_t;
  item_t sbQ[$];

  always #2.5 clk = ~clk;

  amonTop uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .actPulse(actPulse),
    .periodTick(periodTick), .irq(irq)
  );

  // monitor: pops expected items and compares once the read settles
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sbQ.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it = sbQ.pop_front();
        got = (it.addr == IRQ_SEL) ? {31'd0, irq} : regRdData;
        checks++;
        if (got !== it.exp) begin
          errors++;
          $display("FAIL %s addr=%02h actual=%08h expected=%08h", it.req, it.addr, got, it.exp);
        end
      end
    end
  end

  task automatic expect_(input string req, input logic [7:0] a, input logic [31:0] e);
    @(negedge clk);
    regAddr = a;
    sbQ.push_back('{req, a, e});
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic act(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); actPulse = 1'b1;
      @(posedge clk); #1; actPulse = 1'b0;
    end
  endtask

  task automatic tick();
    @(negedge clk); periodTick = 1'b1;
    @(posedge clk); #1; periodTick = 1'b0;
  endtask

  task automatic tickWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    periodTick = 1'b1; regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    periodTick = 1'b0; regWrEn = 1'b0;
  endtask

  task automatic tickAct();
    @(negedge clk); periodTick = 1'b1; actPulse = 1'b1;
    @(posedge clk); #1; periodTick = 1'b0; actPulse = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_();
    idle(3);
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #500000;
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    // R1 reset state
    expect_("R1", 8'h00, 32'h0);
    expect_("R1", 8'h1C, 32'h0);
    expect_("R1", 8'h20, 32'h0);
    expect_("R1", 8'h24, 32'h0);
    expect_("R1", IRQ_SEL, 32'h0);

    // configuration: weight 3, raw marks 20/5, upper needs 2 samples, K=0
    wr(8'h18, 32'd3);
    wr(8'h04, 32'd20);
    wr(8'h08, 32'd5);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h14, 32'd0);
    wr(8'h00, EN | PER | UPEN | DNEN | (32'd1 << 26));
    expect_("R13", 8'h00, 32'hE404_0000);
    expect_("R13", 8'h18, 32'd3);
    expect_("R13", 8'h04, 32'd20);

    act(4); tick();                       // sample 12
    expect_("R2", 8'h1C, 32'd12);
    expect_("R4", 8'h20, 32'd6);
    act(8); tick();                       // 24, run 1
    expect_("R6", 8'h24, 32'h0);
    act(4); tick();                       // 12 breaks run
    expect_("R4", 8'h20, 32'd13);         // 15 + floor(-3/2)
    act(8); tick();                       // 24, run 1 again
    expect_("R6", 8'h24, 32'h0);
    expect_("R4", 8'h20, 32'd18);
    act(8); tick();                       // 24, second consecutive
    expect_("R6", 8'h24, 32'h8000_0000);
    expect_("R10", IRQ_SEL, 32'd1);
    expect_("R4", 8'h20, 32'd21);

    // R9 write-one-to-clear
    wr(8'h24, 32'h4000_0000);
    expect_("R9", 8'h24, 32'h8000_0000);
    wr(8'h24, 32'h8000_0000);
    expect_("R9", 8'h24, 32'h0);
    expect_("R10", IRQ_SEL, 32'd0);

    // R7 lower mark, M=0 -> immediate
    tick();                               // sample 0
    expect_("R7", 8'h24, 32'h4000_0000);
    expect_("R10", IRQ_SEL, 32'd1);
    wr(8'h00, EN | PER | UPEN | (32'd1 << 26));
    expect_("R10", IRQ_SEL, 32'd0);
    wr(8'h24, 32'hFFFF_FFFF);

    // R5 init and R8 average thresholds
    wr(8'h0C, 32'd200);
    expect_("R5", 8'h20, 32'd200);
    wr(8'h10, 32'd90);
    wr(8'h00, EN | PER | UPEN | AUPEN | (32'd1 << 26));
    tick();                               // avg 100 > 90
    expect_("R8", 8'h20, 32'd100);
    expect_("R8", 8'h24, 32'h4100_0000);
    expect_("R10", IRQ_SEL, 32'd1);
    wr(8'h14, 32'd80);
    tick();                               // avg 50 < 80
    expect_("R8", 8'h24, 32'h4300_0000);

    // same-cycle collisions
    wr(8'h24, 32'hFFFF_FFFF);
    expect_("R9", 8'h24, 32'h0);
    tickWr(8'h24, 32'h4000_0000);         // set wins over clear
    expect_("R9", 8'h24, 32'h4200_0000);
    tickWr(8'h0C, 32'd1000);              // load wins over update
    expect_("R5", 8'h20, 32'd1000);

    // R11 periodic gate
    act(2); tick();
    expect_("R2", 8'h1C, 32'd6);
    expect_("R4", 8'h20, 32'd503);
    wr(8'h00, EN | UPEN | AUPEN | (32'd1 << 26));
    act(3); tick();
    expect_("R11", 8'h1C, 32'd6);
    expect_("R11", 8'h20, 32'd503);
    wr(8'h00, EN | PER | UPEN | AUPEN | (32'd1 << 26));
    tick();

    // R3 saturation, R2 pulse in tick cycle goes to next period
    wr(8'h18, 32'hFFFF_FFFF);
    act(2); tick();
    expect_("R3", 8'h1C, 32'hFFFF_FFFF);
    wr(8'h18, 32'd5);
    tickAct();
    expect_("R2", 8'h1C, 32'd0);
    tick();
    expect_("R2", 8'h1C, 32'd5);

    // R12 disable clears status and running total
    tick();                               // sample 0 sets lower bit
    wr(8'h00, PER | UPEN | AUPEN);
    idle(1);
    expect_("R12", 8'h24, 32'h0);
    expect_("R12", IRQ_SEL, 32'd0);
    act(2); tick();
    expect_("R11", 8'h1C, 32'd0);
    wr(8'h00, EN | PER);
    tick();
    expect_("R12", 8'h1C, 32'd0);

    finish_();
  end
endmodule